// File: doc/BRIEF.md
# PHY-Side Link Interface State Monitor

This block lives on the PHY side of a PHY-to-link connection and works out, from the single power/reset control line driven by the link, whether the connection is usable. It tracks four interface conditions: held in reset, disabled, initializing, and fully operational. The control line is read either as a plain level or as a train of pulses. A mode input selects between the two. An isolation-barrier input forces pulse interpretation whatever the mode input says.

While the interface is anything other than operational, the block shields the PHY's request machinery. Link request strobes are not forwarded. Pending bus-request and register-read flags are dropped. Status events are thrown away, so they cannot surface as a status transfer later. Leaving the operational condition raises a single-cycle cancel pulse, and that pulse clears every pending flag.

Top module: `phy_link_guard`

## Requirements
- R1: While `rstN` is low and in the first cycle after it, `ifState` is 0 (reset). `cancelPulse`, `linkReqFwd` and all three pending flags are 0.
- R2: `ifState` encodes reset=0, disabled=1, initializing=2, operational=3. In level mode the line counts as active while it is high. A low-to-high change seen at the inputs is followed by `ifState`=2 two rising edges later, and by `ifState`=3 exactly `INIT_CYCLES` edges after that.
- R3: In pulsed mode only rising edges of the line count as activity. Activity lasts `GAP_LIMIT` cycles past the most recent edge. A line held steadily high therefore cannot keep the interface operational: the interface falls back out of operation and, with no further edges, ends in disabled.
- R4: When `isoBarrier` is 1, the line is read in pulsed mode even if `pulsedMode` is 0.
- R5: When activity is lost in the operational state, `ifState` becomes 0 and `cancelPulse` is 1 for exactly one cycle. In level mode this happens on the second rising edge after the line falls.
- R6: With no activity, the interface stays in reset for `DIS_CYCLES` cycles and then moves to disabled (1). It stays disabled until activity returns.
- R7: Activity lost during initialization returns the interface to reset without a cancel pulse.
- R8: `linkReqFwd` equals `linkReqIn` while operational and is 0 otherwise.
- R9: While operational, a set input raises its pending flag on the next edge. Otherwise an ack input clears it. Set wins over ack in the same cycle. Set inputs are ignored outside operation. All flags are 0 in every cycle that `ifState` is not 3.
- R10: A `statusValidIn` pulse outside operation leaves `statusPend` at 0, both at once and after the interface later becomes operational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lpsIn | input | 1 | Power/reset control line from the link |
| pulsedMode | input | 1 | 1 selects pulse interpretation, 0 selects level |
| isoBarrier | input | 1 | 1 forces pulse interpretation |
| linkReqIn | input | 1 | Link request strobe |
| busReqSet | input | 1 | Raise pending bus request |
| busReqAck | input | 1 | Clear pending bus request |
| regReadSet | input | 1 | Raise pending register-read request |
| regReadAck | input | 1 | Clear pending register-read request |
| statusValidIn | input | 1 | Status event generated by the PHY |
| statusAck | input | 1 | Status transfer taken |
| ifState | output | 2 | Interface condition (0 reset, 1 disabled, 2 init, 3 operational) |
| cancelPulse | output | 1 | One-cycle pulse on leaving operation |
| linkReqFwd | output | 1 | Gated link request |
| busReqPend | output | 1 | Pending bus request |
| regReadPend | output | 1 | Pending register-read request |
| statusPend | output | 1 | Pending status transfer |

## Verification
A wrong interface state shows up directly on `ifState`. It also shows up within one cycle on `linkReqFwd`, because that output is the request gated by the operational state. A stuck pending flag shows up as a nonzero flag after the cancel edge, or as a status flag that survives a resume. A miscounted timer or activity window is caught by checks made on exact edge counts after the line changes. Pulsed-mode and isolation errors show up as an interface that stays operational on a steady line.

// File: rtl/linkmon_pkg.sv
package linkmon_pkg;

  typedef enum logic [1:0] {
    IF_RESET    = 2'd0,
    IF_DISABLED = 2'd1,
    IF_INIT     = 2'd2,
    IF_NORMAL   = 2'd3
  } ifState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic timerClr;
    logic cancel;
    logic normal;
  } ctlStrobe_t;

endpackage

// File: rtl/linkmon_datapath.sv
module linkmon_datapath
  import linkmon_pkg::*;
#(
  parameter int GAP_LIMIT = 64,
  parameter int TIMER_MAX = 32,
  localparam int GAP_W   = $clog2(GAP_LIMIT + 1),
  localparam int TIMER_W = $clog2(TIMER_MAX + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lpsIn,
  input  logic               pulsedMode,
  input  logic               isoBarrier,
  input  ctlStrobe_t         strb,
  input  logic               busReqSet,
  input  logic               busReqAck,
  input  logic               regReadSet,
  input  logic               regReadAck,
  input  logic               statusValidIn,
  input  logic               statusAck,
  output logic               lpsActive,
  output logic [TIMER_W-1:0] timerVal,
  output logic               busReqPend,
  output logic               regReadPend,
  output logic               statusPend
);

  logic             lpsQ;
  logic             lpsPrev;
  logic [GAP_W-1:0] gapCnt;
  logic             riseSeen;
  logic             usePulses;

  assign usePulses = pulsedMode | isoBarrier;
  assign riseSeen  = lpsQ & ~lpsPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lpsQ    <= 1'b0;
      lpsPrev <= 1'b0;
    end else begin
      lpsQ    <= lpsIn;
      lpsPrev <= lpsQ;
    end
  end

  // cycles since the last rising edge, saturating at the limit
  always_ff @(posedge clk) begin
    if (!rstN)
      gapCnt <= GAP_W'(GAP_LIMIT);
    else if (riseSeen)
      gapCnt <= '0;
    else if (gapCnt != GAP_W'(GAP_LIMIT))
      gapCnt <= gapCnt + 1'b1;
  end

  always_comb begin
    if (usePulses)
      lpsActive = riseSeen | (gapCnt < GAP_W'(GAP_LIMIT));
    else
      lpsActive = lpsQ;
  end

  // shared phase timer for reset dwell and initialization
  always_ff @(posedge clk) begin
    if (!rstN)
      timerVal <= '0;
    else if (strb.timerClr)
      timerVal <= '0;
    else if (timerVal != TIMER_W'(TIMER_MAX))
      timerVal <= timerVal + 1'b1;
  end

  // pending flags: cancel first, then set (only when operational), then ack
  logic [2:0] setVec, ackVec, pendQ;
  assign setVec = {statusValidIn, regReadSet, busReqSet};
  assign ackVec = {statusAck, regReadAck, busReqAck};

  for (genvar i = 0; i < 3; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN || strb.cancel)
        pendQ[i] <= 1'b0;
      else if (setVec[i] && strb.normal)
        pendQ[i] <= 1'b1;
      else if (ackVec[i])
        pendQ[i] <= 1'b0;
    end
  end

  assign busReqPend  = pendQ[0];
  assign regReadPend = pendQ[1];
  assign statusPend  = pendQ[2];

endmodule

// File: rtl/linkmon_control.sv
module linkmon_control
  import linkmon_pkg::*;
#(
  parameter int DIS_CYCLES  = 32,
  parameter int INIT_CYCLES = 16,
  parameter int TIMER_W     = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lpsActive,
  input  logic [TIMER_W-1:0] timerVal,
  output ifState_e           state,
  output ctlStrobe_t         strb,
  output logic               cancelPulse
);

  ifState_e nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      IF_RESET: begin
        if (lpsActive)
          nextState = IF_INIT;
        else if (timerVal == TIMER_W'(DIS_CYCLES - 1))
          nextState = IF_DISABLED;
      end
      IF_DISABLED: if (lpsActive) nextState = IF_INIT;
      IF_INIT: begin
        if (!lpsActive)
          nextState = IF_RESET;
        else if (timerVal == TIMER_W'(INIT_CYCLES - 1))
          nextState = IF_NORMAL;
      end
      IF_NORMAL: if (!lpsActive) nextState = IF_RESET;
      default: nextState = IF_RESET;
    endcase
  end

  always_comb begin
    strb.timerClr = (nextState != state);
    strb.normal   = (state == IF_NORMAL);
    strb.cancel   = (state == IF_NORMAL) && (nextState != IF_NORMAL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= IF_RESET;
      cancelPulse <= 1'b0;
    end else begin
      state       <= nextState;
      cancelPulse <= strb.cancel;
    end
  end

endmodule

// File: rtl/phy_link_guard.sv
module phy_link_guard
  import linkmon_pkg::*;
#(
  parameter int GAP_LIMIT   = 64,
  parameter int DIS_CYCLES  = 32,
  parameter int INIT_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lpsIn,
  input  logic       pulsedMode,
  input  logic       isoBarrier,
  input  logic       linkReqIn,
  input  logic       busReqSet,
  input  logic       busReqAck,
  input  logic       regReadSet,
  input  logic       regReadAck,
  input  logic       statusValidIn,
  input  logic       statusAck,
  output logic [1:0] ifState,
  output logic       cancelPulse,
  output logic       linkReqFwd,
  output logic       busReqPend,
  output logic       regReadPend,
  output logic       statusPend
);

  localparam int TIMER_MAX = (DIS_CYCLES > INIT_CYCLES) ? DIS_CYCLES : INIT_CYCLES;
  localparam int TIMER_W   = $clog2(TIMER_MAX + 1);

  ctlStrobe_t         strb;
  ifState_e           stateQ;
  logic               lpsActive;
  logic [TIMER_W-1:0] timerVal;

  linkmon_datapath #(
    .GAP_LIMIT (GAP_LIMIT),
    .TIMER_MAX (TIMER_MAX)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .lpsIn         (lpsIn),
    .pulsedMode    (pulsedMode),
    .isoBarrier    (isoBarrier),
    .strb          (strb),
    .busReqSet     (busReqSet),
    .busReqAck     (busReqAck),
    .regReadSet    (regReadSet),
    .regReadAck    (regReadAck),
    .statusValidIn (statusValidIn),
    .statusAck     (statusAck),
    .lpsActive     (lpsActive),
    .timerVal      (timerVal),
    .busReqPend    (busReqPend),
    .regReadPend   (regReadPend),
    .statusPend    (statusPend)
  );

  linkmon_control #(
    .DIS_CYCLES  (DIS_CYCLES),
    .INIT_CYCLES (INIT_CYCLES),
    .TIMER_W     (TIMER_W)
  ) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .lpsActive   (lpsActive),
    .timerVal    (timerVal),
    .state       (stateQ),
    .strb        (strb),
    .cancelPulse (cancelPulse)
  );

  assign ifState    = stateQ;
  assign linkReqFwd = linkReqIn & strb.normal;

endmodule

// File: rtl/linkmon_checker.sv
module linkmon_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] ifState,
  input logic       cancelPulse,
  input logic       linkReqIn,
  input logic       linkReqFwd,
  input logic       busReqPend,
  input logic       regReadPend,
  input logic       statusPend
);

  // R5: cancel lasts a single cycle
  p_cancel_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    cancelPulse |=> !cancelPulse);

  // R5: cancel only right after leaving operation into reset
  p_cancel_from_normal_r5: assert property (@(posedge clk) disable iff (!rstN)
    cancelPulse |-> ($past(ifState) == 2'd3) && (ifState == 2'd0));

  // R9: no pending flag outside operation
  p_flags_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ifState != 2'd3) |-> !(busReqPend || regReadPend || statusPend));

  // R8: requests pass only while operational
  p_req_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    linkReqFwd |-> (linkReqIn && ifState == 2'd3));

  // R2: operation is entered only from initialization
  p_normal_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ifState == 2'd3 && $past(ifState) != 2'd3) |-> $past(ifState) == 2'd2);

  // R6: disabled is entered only from reset
  p_disable_entry_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ifState == 2'd1 && $past(ifState) != 2'd1) |-> $past(ifState) == 2'd0);

  // R7: leaving init without cancel
  p_init_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ifState) == 2'd2 && ifState == 2'd0) |-> !cancelPulse);

endmodule

bind phy_link_guard linkmon_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .ifState     (ifState),
  .cancelPulse (cancelPulse),
  .linkReqIn   (linkReqIn),
  .linkReqFwd  (linkReqFwd),
  .busReqPend  (busReqPend),
  .regReadPend (regReadPend),
  .statusPend  (statusPend)
);

// File: tb/tb_phy_link_guard.sv
module tb_phy_link_guard;

  localparam int GAP  = 64;
  localparam int DIS  = 32;
  localparam int INIT = 16;

  logic clk = 1'b0;
  logic rstN;
  logic lpsIn, pulsedMode, isoBarrier, linkReqIn;
  logic busReqSet, busReqAck, regReadSet, regReadAck, statusValidIn, statusAck;
  logic [1:0] ifState;
  logic cancelPulse, linkReqFwd, busReqPend, regReadPend, statusPend;

  int checks = 0;
  int failures = 0;
  int cancelCnt = 0;
  int cycleCnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  phy_link_guard #(.GAP_LIMIT(GAP), .DIS_CYCLES(DIS), .INIT_CYCLES(INIT)) dut (
    .clk(clk), .rstN(rstN), .lpsIn(lpsIn), .pulsedMode(pulsedMode),
    .isoBarrier(isoBarrier), .linkReqIn(linkReqIn),
    .busReqSet(busReqSet), .busReqAck(busReqAck),
    .regReadSet(regReadSet), .regReadAck(regReadAck),
    .statusValidIn(statusValidIn), .statusAck(statusAck),
    .ifState(ifState), .cancelPulse(cancelPulse), .linkReqFwd(linkReqFwd),
    .busReqPend(busReqPend), .regReadPend(regReadPend), .statusPend(statusPend)
  );

  always @(negedge clk) if (cancelPulse) cancelCnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit nextFlag(input bit cur, input bit setI, input bit ackI);
    if (setI) return 1'b1;
    if (ackI) return 1'b0;
    return cur;
  endfunction

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quietReqs();
    linkReqIn = 0; busReqSet = 0; busReqAck = 0; regReadSet = 0;
    regReadAck = 0; statusValidIn = 0; statusAck = 0;
  endtask

  // hold lps low long enough to settle in disabled
  task automatic settleDisabled();
    lpsIn = 0;
    waitN(GAP + DIS + 8);
  endtask

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt > 100000 && !done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycleCnt);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit eb, er, es;
    void'($urandom(32'd4711));
    rstN = 0; lpsIn = 0; pulsedMode = 0; isoBarrier = 0;
    quietReqs();
    waitN(4);
    chk("R1 state", ifState, 0);
    chk("R1 outputs", {cancelPulse, linkReqFwd, busReqPend, regReadPend, statusPend}, 0);
    rstN = 1;
    waitN(1);
    chk("R1 first cycle", ifState, 0);

    // R6 dwell in reset then disabled
    waitN(DIS - 2);
    chk("R6 still reset", ifState, 0);
    waitN(1);
    chk("R6 disabled", ifState, 1);

    // R10 status outside operation is discarded
    statusValidIn = 1; busReqSet = 1; regReadSet = 1; linkReqIn = 1;
    #1 chk("R8 gated when disabled", linkReqFwd, 0);
    waitN(1);
    quietReqs();
    chk("R10 status dropped", statusPend, 0);
    chk("R9 set ignored", {busReqPend, regReadPend}, 0);

    // R2 level entry timing
    lpsIn = 1;
    waitN(1);
    chk("R2 one edge", ifState, 1);
    waitN(1);
    chk("R2 init", ifState, 2);
    waitN(INIT - 1);
    chk("R2 init end", ifState, 2);
    waitN(1);
    chk("R2 operational", ifState, 3);
    chk("R10 no status after resume", statusPend, 0);

    // R8/R9 random traffic while operational
    eb = 0; er = 0; es = 0;
    for (int i = 0; i < 400; i++) begin
      bit bs, ba, rs, ra, sv, sa, lr;
      chk("R9 bus flag", busReqPend, eb);
      chk("R9 read flag", regReadPend, er);
      chk("R9 status flag", statusPend, es);
      bs = ($urandom % 4) == 0; ba = ($urandom % 3) == 0;
      rs = ($urandom % 4) == 0; ra = ($urandom % 3) == 0;
      sv = ($urandom % 4) == 0; sa = ($urandom % 3) == 0;
      lr = $urandom % 2;
      busReqSet = bs; busReqAck = ba; regReadSet = rs; regReadAck = ra;
      statusValidIn = sv; statusAck = sa; linkReqIn = lr;
      #1 chk("R8 forward", linkReqFwd, lr);
      eb = nextFlag(eb, bs, ba); er = nextFlag(er, rs, ra); es = nextFlag(es, sv, sa);
      waitN(1);
    end
    // leave all flags set
    busReqSet = 1; regReadSet = 1; statusValidIn = 1;
    waitN(1);
    quietReqs();
    chk("R9 flags set", {busReqPend, regReadPend, statusPend}, 7);

    // R5 loss in level mode
    cancelCnt = 0;
    lpsIn = 0;
    waitN(1);
    chk("R5 still operational", ifState, 3);
    chk("R5 no early cancel", cancelPulse, 0);
    waitN(1);
    chk("R5 reset", ifState, 0);
    chk("R5 cancel", cancelPulse, 1);
    chk("R9 flags cleared", {busReqPend, regReadPend, statusPend}, 0);
    waitN(1);
    chk("R5 cancel single", cancelPulse, 0);
    waitN(DIS - 1);
    chk("R6 disabled after loss", ifState, 1);
    chk("R5 cancel count", cancelCnt, 1);

    // R7 drop during init
    cancelCnt = 0;
    lpsIn = 1;
    waitN(5);
    chk("R7 in init", ifState, 2);
    lpsIn = 0;
    waitN(2);
    chk("R7 back to reset", ifState, 0);
    chk("R7 no cancel", cancelCnt, 0);
    settleDisabled();

    // R3 pulsed mode keeps running on edges
    pulsedMode = 1;
    for (int i = 0; i < 200; i++) begin
      lpsIn = (i % 8) < 4;
      waitN(1);
    end
    chk("R3 pulses keep operational", ifState, 3);
    lpsIn = 0;
    settleDisabled();

    // R3 steady high in pulsed mode
    cancelCnt = 0;
    lpsIn = 1;
    waitN(GAP + DIS + 50);
    chk("R3 steady high not held", ifState, 1);
    chk("R3 one cancel", cancelCnt, 1);
    lpsIn = 0;
    settleDisabled();

    // R4 isolation forces pulsed reading
    pulsedMode = 0; isoBarrier = 1; cancelCnt = 0;
    lpsIn = 1;
    waitN(GAP + DIS + 50);
    chk("R4 iso forces pulsed", ifState, 1);
    chk("R4 one cancel", cancelCnt, 1);
    lpsIn = 0;
    waitN(4);
    isoBarrier = 0;
    lpsIn = 1;
    waitN(INIT + 4);
    chk("R4 level without iso", ifState, 3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule